// File: doc/BRIEF.md
# Mode-Controlled GPIO Data Port

This block is an eight-pin general-purpose I/O port controlled through a small register bus. It holds a data register and a mode register. The mode register has a two-bit field for each pin, and each field picks one of four functions for that pin:

| Code | Pin function |
|------|--------------|
| `00` | Alternate peripheral function |
| `01` | Push output |
| `10` | Input with pull-up |
| `11` | Input without pull-up |

For every pin the block drives the pad-side signals: output value, output enable and pull-up enable. It also decides, bit by bit, whether a register read returns the stored data bit or the pin level.

The pin levels pass through a two-flop synchronizer before they reach the read path. A write to the data register always updates the register, whatever the mode. The written value reaches the pin only in push-output mode.

There are two reset inputs. The power-on reset clears the data register and puts every pin into input-with-pull-up mode. The manual reset leaves both registers untouched and blocks bus writes while it is asserted.

Top module: `gpio_mode_port`

## Requirements
- R1: While and after power-on reset (`por_n` low), the data register is 0x00 and every mode field is `10`. A read of the mode register therefore returns 0xAAAA. `pin_pu` is all ones and `pin_oe` is all zeros.
- R2: A bus write with `wr_en` and `sel_data` high updates data bits [7:0] from `wdata[7:0]` on the next rising clock edge. In modes `00` and `01`, a read of that bit returns the stored data bit.
- R3: In modes `10` and `11`, a read of bit n returns `pin_in[n]` as it was two rising edges earlier. The two-flop synchronizer supplies this delay.
- R4: In modes `10` and `11` a data write is still stored, but `pin_out[n]` is 0 and `pin_oe[n]` is 0. If the pin is later switched to mode `01`, the stored value appears on the pin.
- R5: In mode `01`, `pin_oe[n]` is 1 and `pin_out[n]` equals data bit n.
- R6: In mode `00`, `pin_out[n]` follows `alt_out[n]` and `pin_oe[n]` follows `alt_oe[n]`. A read of bit n returns the data bit.
- R7: `pin_pu[n]` is 1 exactly when the mode of pin n is `10`.
- R8: While `mrst_n` is low, the data register and the mode register keep their contents and all bus writes are ignored. Both registers still hold the same values after `mrst_n` rises.
- R9: Read path:
  - With `sel_data` high, `rdata` is the eight read-back bits, zero-extended to 16 bits.
  - Otherwise, with `sel_mode` high, `rdata` is the mode register, with pin n at bits [2n+1:2n].
  - With neither select high, `rdata` is 0.
  - `sel_data` takes priority over `sel_mode` for both reads and writes.
- R10: A write with `wr_en` and `sel_mode` high, and `sel_data` low, loads the mode register from `wdata` on the next rising edge. Each pin then behaves by its own field, independently of the other pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low; blocks writes, keeps registers |
| sel_data | input | 1 | Selects the data register |
| sel_mode | input | 1 | Selects the mode register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| pin_in | input | 8 | Pad input levels |
| alt_out | input | 8 | Output values from the alternate function |
| alt_oe | input | 8 | Output enables from the alternate function |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
The bench targets the following corner cases:

- **Synchronizer latency.** The bench checks the read one edge after a pin change as well as two edges after it. A missing stage, or an extra stage, returns the new level too early or too late.
- **Mixed modes.** With four different modes set on neighbouring pins, one read catches a mux that selects on the wrong mode bit or on a shifted field.
- **Writes in input modes.** These must be stored but kept off the pad. A design that gates the write loses the value when the pin later becomes an output. A design that drives the pad anyway shows the value on `pin_out`.
- **Manual reset.** A design that treats it like power-on reset returns 0x00 and 0xAAAA afterwards. One that does not block writes returns the values written during the reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      PM_ALT     = 2'b00,
      PM_OUT     = 2'b01,
      PM_IN_PU   = 2'b10,
      PM_IN_NOPU = 2'b11
   } pin_mode_e;

   localparam logic [1:0] MODE_AFTER_POR = PM_IN_PU;
endpackage

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
   import gpio_port_pkg::*;
#(
   parameter int PIN_COUNT = 8
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   mrst_n,
   input  logic                   sel_data,
   input  logic                   sel_mode,
   input  logic                   wr_en,
   input  logic [2*PIN_COUNT-1:0] wdata,
   output logic [PIN_COUNT-1:0]   data_q,
   output logic [2*PIN_COUNT-1:0] mode_q
);
   localparam int MODE_W = 2 * PIN_COUNT;
   localparam logic [MODE_W-1:0] MODE_RST = {PIN_COUNT{MODE_AFTER_POR}};

   logic data_we, mode_we;

   // manual reset blocks writes but clears nothing
   assign data_we = wr_en && sel_data && mrst_n;
   assign mode_we = wr_en && sel_mode && !sel_data && mrst_n;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         data_q <= '0;
      end else if (data_we) begin
         data_q <= wdata[PIN_COUNT-1:0];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q <= MODE_RST;
      end else if (mode_we) begin
         mode_q <= wdata;
      end
   end

   assert_data_write_R2: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && sel_data && mrst_n) |=> data_q == $past(wdata[PIN_COUNT-1:0]));

   assert_mode_write_R10: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && sel_mode && !sel_data && mrst_n) |=> mode_q == $past(wdata));

   assert_mrst_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> ($stable(data_q) && $stable(mode_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int CNT_W = $clog2(STAGES + 1);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

   // edges seen since power-on reset, saturating at STAGES
   logic [CNT_W-1:0] warm_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         warm_q <= '0;
      end else if (warm_q != CNT_W'(STAGES)) begin
         warm_q <= warm_q + 1'b1;
      end
   end

   if (STAGES == 2) begin : g_chk2
      assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!por_n)
         (warm_q == CNT_W'(STAGES)) |-> sync_o == $past(async_i, 2));
   end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_port_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       data_i,
   input  logic       sync_i,
   input  logic       alt_out_i,
   input  logic       alt_oe_i,
   output logic       pin_out_o,
   output logic       pin_oe_o,
   output logic       pin_pu_o,
   output logic       rd_bit_o
);
   pin_mode_e mode;
   assign mode = pin_mode_e'(mode_i);

   always_comb begin
      pin_out_o = 1'b0;
      pin_oe_o  = 1'b0;
      pin_pu_o  = 1'b0;
      rd_bit_o  = data_i;
      case (mode)
         PM_ALT: begin
            pin_out_o = alt_out_i;
            pin_oe_o  = alt_oe_i;
         end
         PM_OUT: begin
            pin_out_o = data_i;
            pin_oe_o  = 1'b1;
         end
         PM_IN_PU: begin
            pin_pu_o = 1'b1;
            rd_bit_o = sync_i;
         end
         default: begin
            rd_bit_o = sync_i;
         end
      endcase
   end
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port #(
   parameter int PIN_COUNT   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BUS_W       = 2 * PIN_COUNT
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 mrst_n,
   input  logic                 sel_data,
   input  logic                 sel_mode,
   input  logic                 wr_en,
   input  logic [BUS_W-1:0]     wdata,
   output logic [BUS_W-1:0]     rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   input  logic [PIN_COUNT-1:0] alt_out,
   input  logic [PIN_COUNT-1:0] alt_oe,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic [PIN_COUNT-1:0] pin_pu
);
   localparam int PAD_W = BUS_W - PIN_COUNT;

   if (PIN_COUNT < 1 || PIN_COUNT > 16) begin : g_bad_count
      $error("gpio_mode_port: PIN_COUNT out of range 1..16");
   end
   if (BUS_W != 2 * PIN_COUNT) begin : g_bad_bus
      $error("gpio_mode_port: BUS_W must equal 2*PIN_COUNT");
   end

   logic [PIN_COUNT-1:0] data_q;
   logic [BUS_W-1:0]     mode_q;
   logic [PIN_COUNT-1:0] sync_bits;
   logic [PIN_COUNT-1:0] rd_bits;

   gpio_bus_regs #(.PIN_COUNT(PIN_COUNT)) i_regs (
      .clk      (clk),
      .por_n    (por_n),
      .mrst_n   (mrst_n),
      .sel_data (sel_data),
      .sel_mode (sel_mode),
      .wr_en    (wr_en),
      .wdata    (wdata),
      .data_q   (data_q),
      .mode_q   (mode_q)
   );

   gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .por_n   (por_n),
      .async_i (pin_in),
      .sync_o  (sync_bits)
   );

   for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
      gpio_pin_ctrl i_ctrl (
         .mode_i    (mode_q[2*n +: 2]),
         .data_i    (data_q[n]),
         .sync_i    (sync_bits[n]),
         .alt_out_i (alt_out[n]),
         .alt_oe_i  (alt_oe[n]),
         .pin_out_o (pin_out[n]),
         .pin_oe_o  (pin_oe[n]),
         .pin_pu_o  (pin_pu[n]),
         .rd_bit_o  (rd_bits[n])
      );

      assert_out_enable_R5: assert property (@(posedge clk) disable iff (!por_n)
         (mode_q[2*n +: 2] == 2'b01) |-> (pin_oe[n] && pin_out[n] == data_q[n]));

      assert_input_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
         mode_q[2*n+1] |-> (!pin_oe[n] && !pin_out[n]));

      assert_pullup_R7: assert property (@(posedge clk) disable iff (!por_n)
         pin_pu[n] == (mode_q[2*n +: 2] == 2'b10));

      assert_input_read_R3: assert property (@(posedge clk) disable iff (!por_n)
         (sel_data && mode_q[2*n+1]) |-> rdata[n] == sync_bits[n]);
   end

   always_comb begin
      if (sel_data) begin
         rdata = {{PAD_W{1'b0}}, rd_bits};
      end else if (sel_mode) begin
         rdata = mode_q;
      end else begin
         rdata = '0;
      end
   end

   assert_idle_read_R9: assert property (@(posedge clk) disable iff (!por_n)
      (!sel_data && !sel_mode) |-> rdata == '0);

   assert_data_read_upper_R9: assert property (@(posedge clk) disable iff (!por_n)
      sel_data |-> rdata[BUS_W-1:PIN_COUNT] == '0);
endmodule

// File: tb/test_gpio_mode_port.sv
`timescale 1ns/1ps
module test_gpio_mode_port;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        mrst_n = 1'b1;
   logic        sel_data = 1'b0;
   logic        sel_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  alt_out = '0;
   logic [7:0]  alt_oe = '0;
   logic [7:0]  pin_out, pin_oe, pin_pu;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   gpio_mode_port i_gpio_mode_port (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
      .sel_data(sel_data), .sel_mode(sel_mode), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
      .alt_out(alt_out), .alt_oe(alt_oe),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input bit to_data, input bit to_mode, input logic [15:0] v);
      @(negedge clk);
      sel_data = to_data; sel_mode = to_mode; wr_en = 1'b1; wdata = v;
      @(negedge clk);
      sel_data = 1'b0; sel_mode = 1'b0; wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input bit from_data, input bit from_mode, output logic [15:0] v);
      @(negedge clk);
      sel_data = from_data; sel_mode = from_mode;
      #1 v = rdata;
      @(negedge clk);
      sel_data = 1'b0; sel_mode = 1'b0;
   endtask

   // read value per R2/R3/R6: data bit for modes 00/01, pin level for 1x
   function automatic logic [15:0] exp_read(input logic [15:0] m, input logic [7:0] d,
                                            input logic [7:0] p);
      logic [15:0] r = '0;
      for (int k = 0; k < 8; k++) r[k] = m[2*k+1] ? p[k] : d[k];
      return r;
   endfunction

   task automatic t_reset_state;
      logic [15:0] v;
      check("R1 pin_pu", {8'h0, pin_pu}, 16'h00FF);
      check("R1 pin_oe", {8'h0, pin_oe}, 16'h0000);
      bus_read(0, 1, v); check("R1 mode reset", v, 16'hAAAA);
      bus_write(0, 1, 16'h5555);
      bus_read(1, 0, v); check("R1 data reset", v, 16'h0000);
      bus_read(0, 0, v); check("R9 idle read", v, 16'h0000);
   endtask

   task automatic t_output_mode;
      logic [15:0] v;
      bus_write(1, 0, 16'hFFA5);
      bus_read(1, 0, v); check("R2 data read", v, 16'h00A5);
      check("R5 pin_out", {8'h0, pin_out}, 16'h00A5);
      check("R5 pin_oe", {8'h0, pin_oe}, 16'h00FF);
      check("R7 pin_pu off", {8'h0, pin_pu}, 16'h0000);
      bus_read(1, 1, v); check("R9 data priority", v, 16'h00A5);
   endtask

   task automatic t_input_sync;
      logic [15:0] v;
      bus_write(0, 1, 16'hFFFF);
      @(negedge clk); pin_in = 8'h3C; sel_data = 1'b1;
      @(posedge clk); #1 check("R3 one edge old", rdata, 16'h0000);
      @(posedge clk); #1 check("R3 two edges new", rdata, 16'h003C);
      @(negedge clk); sel_data = 1'b0;
      check("R7 no pull-up mode 11", {8'h0, pin_pu}, 16'h0000);
      bus_write(0, 1, 16'hAAAA);
      check("R7 pull-up mode 10", {8'h0, pin_pu}, 16'h00FF);
      bus_read(1, 0, v); check("R3 pull-up mode read", v, 16'h003C);
   endtask

   task automatic t_write_in_input;
      logic [15:0] v;
      bus_write(1, 0, 16'h005A);
      check("R4 pin_out quiet", {8'h0, pin_out}, 16'h0000);
      check("R4 pin_oe quiet", {8'h0, pin_oe}, 16'h0000);
      bus_read(1, 0, v); check("R4 reads pins", v, 16'h003C);
      bus_write(0, 1, 16'h5555);
      check("R4 stored value appears", {8'h0, pin_out}, 16'h005A);
   endtask

   task automatic t_alt_mode;
      logic [15:0] v;
      alt_out = 8'hC3; alt_oe = 8'h0F;
      bus_write(0, 1, 16'h0000);
      #1 check("R6 alt out", {8'h0, pin_out}, 16'h00C3);
      check("R6 alt oe", {8'h0, pin_oe}, 16'h000F);
      bus_read(1, 0, v); check("R6 read data", v, 16'h005A);
      alt_out = 8'h00; alt_oe = 8'h00;
   endtask

   task automatic t_mixed;
      logic [15:0] v, m;
      m = 16'h55E4;  // pin0=00 pin1=01 pin2=10 pin3=11 others 01
      alt_out = 8'h01; alt_oe = 8'h01;
      pin_in = 8'h0C;
      bus_write(1, 0, 16'h0033);
      bus_write(0, 1, m);
      repeat (2) @(negedge clk);
      bus_read(0, 1, v); check("R10 mode read", v, m);
      bus_read(1, 0, v); check("R10 mixed read", v, exp_read(m, 8'h33, 8'h0C));
      check("R10 mixed oe", {8'h0, pin_oe}, 16'h00F3);
      check("R10 mixed out", {8'h0, pin_out}, 16'h0033);
      check("R7 mixed pu", {8'h0, pin_pu}, 16'h0004);
      alt_out = 8'h00; alt_oe = 8'h00;
   endtask

   task automatic t_manual_reset;
      logic [15:0] v;
      bus_write(0, 1, 16'h5555);
      bus_write(1, 0, 16'h003C);
      @(negedge clk); mrst_n = 1'b0;
      bus_write(1, 0, 16'h00FF);
      bus_write(0, 1, 16'h0000);
      check("R8 pin held in mrst", {8'h0, pin_out}, 16'h003C);
      @(negedge clk); mrst_n = 1'b1;
      bus_read(1, 0, v); check("R8 data kept", v, 16'h003C);
      bus_read(0, 1, v); check("R8 mode kept", v, 16'h5555);
   endtask

   task automatic t_por_again;
      logic [15:0] v;
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      bus_read(0, 1, v); check("R1 por mode", v, 16'hAAAA);
      bus_write(0, 1, 16'h5555);
      bus_read(1, 0, v); check("R1 por data", v, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      t_reset_state();
      t_output_mode();
      t_input_sync();
      t_write_in_input();
      t_alt_mode();
      t_mixed();
      t_manual_reset();
      t_por_again();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule